// File: doc/BRIEF.md
# Serial GFC Nibble Insertion Port

This block sits in the transmit path after the cell processor and fills the Generic Flow Control field of outgoing ATM cells from an external serial source. The processor streams header bytes to it, one byte per beat, with a start-of-cell marker and a flag that tells a user cell from an idle cell. For a user cell with insertion turned on, the block holds the first header byte back. It then drives a serial clock and an MSB strobe, collects four serial bits and releases the byte with its upper nibble replaced.

The external source watches the strobe and the serial clock. It presents the nibble's most significant bit while the strobe is high. It changes to the next bit on each falling edge of the serial clock, and the block samples on the rising edge. Idle cells, cells that arrive while insertion is off, and every byte after the first header byte pass straight through with no serial activity. The serial clock runs at the system clock divided by twice `SCLK_HALF`, and it runs only during a capture.

Top module: `gfc_serial_insert`

## Requirements
- R1: After reset the serial clock and the MSB strobe are low and `in_ready` follows `out_ready`.
- R2: When a start-of-cell beat of a user cell (`in_cell_ok`=1) arrives with `enable`=1, `in_ready` and `out_valid` stay low from that cycle until all four serial bits have been captured.
- R3: During a capture the MSB strobe is high for exactly one serial bit period (2·`SCLK_HALF` clock cycles), the first of the four, and it is low at all other times.
- R4: A capture produces exactly four rising edges of the serial clock, one bit period apart. `gfc_sdi` is sampled at each rising edge.
- R5: Bits arrive MSB first. The first sampled bit becomes bit 7 of the released byte, then bits 6, 5 and 4 in sample order.
- R6: Bits 3:0 of every byte presented downstream equal bits 3:0 of the byte presented upstream.
- R7: Idle cells (`in_cell_ok`=0) pass unchanged, with no serial clock edge and no strobe.
- R8: With `enable`=0, cells pass unchanged with no serial clock edge and no strobe.
- R9: Beats without the start-of-cell marker pass unchanged, with `in_ready` equal to `out_ready` and no stall.
- R10: While the modified header byte is waiting and `out_ready` is low, `out_valid` stays high and the inserted nibble stays stable. It is consumed on the first cycle with `out_ready` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Turns nibble insertion on |
| in_valid | input | 1 | Upstream beat valid |
| in_data | input | 8 | Upstream header/payload byte |
| in_sop | input | 1 | Beat is the first header byte of a cell |
| in_cell_ok | input | 1 | 1 = user cell, 0 = idle cell |
| in_ready | output | 1 | Block accepts the upstream beat |
| out_valid | output | 1 | Downstream beat valid |
| out_data | output | 8 | Downstream byte, nibble inserted on header byte |
| out_sop | output | 1 | Start-of-cell marker passed downstream |
| out_cell_ok | output | 1 | User/idle flag passed downstream |
| out_ready | input | 1 | Downstream accepts the beat |
| gfc_sclk | output | 1 | Serial bit clock to the nibble source |
| gfc_msb | output | 1 | High during the MSB bit period |
| gfc_sdi | input | 1 | Serial nibble data |

## Verification
On every cycle the assertions check that the stream is stalled during a capture, that the serial clock and strobe are quiet outside a capture, the exact strobe width, lower-nibble preservation, nibble stability under back-pressure and pass-through while disabled. Only the bench scenarios can show that a given bit sequence from the external source lands in the right bit positions, MSB first. The same holds for the count of serial clock edges per capture and for the separate behaviour of idle, disabled and payload beats.

// File: rtl/gfc_pkg.sv
package gfc_pkg;
  localparam int HDR_W = 8;
  localparam int GFC_W = 4;

  typedef enum logic [1:0] {
    ST_PASS = 2'd0,
    ST_CAPT = 2'd1,
    ST_INS  = 2'd2
  } ins_state_t;

  // Upper nibble taken from the captured value, lower nibble kept.
  function automatic logic [HDR_W-1:0] merge_gfc(input logic [GFC_W-1:0] nib,
                                                  input logic [HDR_W-1:0] hdr);
    return {nib, hdr[HDR_W-GFC_W-1:0]};
  endfunction
endpackage

// File: rtl/gfc_sclk_gen.sv
module gfc_sclk_gen #(
  parameter int SCLK_HALF = 2,
  parameter int NBITS     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic sclk,
  output logic msb,
  output logic sample_en,
  output logic done
);
  localparam int PER = 2 * SCLK_HALF;
  localparam int PW  = (PER > 1) ? $clog2(PER) : 1;
  localparam int BW  = (NBITS > 1) ? $clog2(NBITS) : 1;

  logic          run;
  logic [PW-1:0] phase;
  logic [BW-1:0] bidx;
  logic          last_phase;

  assign last_phase = (phase == PW'(PER - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      phase <= '0;
      bidx  <= '0;
    end else if (start) begin
      run   <= 1'b1;
      phase <= '0;
      bidx  <= '0;
    end else if (run) begin
      if (last_phase) begin
        phase <= '0;
        if (bidx == BW'(NBITS - 1)) run <= 1'b0;
        else                        bidx <= bidx + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  assign busy      = run;
  assign sclk      = run && (phase >= PW'(SCLK_HALF));
  assign msb       = run && (bidx == '0);
  assign sample_en = run && (phase == PW'(SCLK_HALF - 1));
  assign done      = run && last_phase && (bidx == BW'(NBITS - 1));
endmodule

// File: rtl/gfc_shift_rx.sv
module gfc_shift_rx #(
  parameter int NBITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             shift_en,
  input  logic             sdi,
  output logic [NBITS-1:0] nib
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        nib <= '0;
    else if (clear)    nib <= '0;
    else if (shift_en) nib <= {nib[NBITS-2:0], sdi};
  end
endmodule

// File: rtl/gfc_ctrl.sv
module gfc_ctrl
  import gfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       in_valid,
  input  logic       in_sop,
  input  logic       in_cell_ok,
  input  logic       cap_done,
  input  logic       out_ready,
  output logic       start,
  output logic       in_ready,
  output logic       out_valid,
  output ins_state_t st
);
  ins_state_t st_nx;
  logic       trigger;

  assign trigger = (st == ST_PASS) && in_valid && in_sop && in_cell_ok && enable;
  assign start   = trigger;

  always_comb begin
    st_nx     = st;
    in_ready  = 1'b0;
    out_valid = 1'b0;
    unique case (st)
      ST_PASS: begin
        in_ready  = out_ready && !trigger;
        out_valid = in_valid && !trigger;
        if (trigger) st_nx = ST_CAPT;
      end
      ST_CAPT: begin
        if (cap_done) st_nx = ST_INS;
      end
      ST_INS: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        if (in_valid && out_ready) st_nx = ST_PASS;
      end
      default: st_nx = ST_PASS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_PASS;
    else        st <= st_nx;
  end
endmodule

// File: rtl/gfc_serial_insert.sv
module gfc_serial_insert
  import gfc_pkg::*;
#(
  parameter int SCLK_HALF = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             in_valid,
  input  logic [HDR_W-1:0] in_data,
  input  logic             in_sop,
  input  logic             in_cell_ok,
  output logic             in_ready,
  output logic             out_valid,
  output logic [HDR_W-1:0] out_data,
  output logic             out_sop,
  output logic             out_cell_ok,
  input  logic             out_ready,
  output logic             gfc_sclk,
  output logic             gfc_msb,
  input  logic             gfc_sdi
);
  // Internal events, named for the checker
  logic             cap_start;
  logic             cap_sample;
  logic             cap_done;
  logic             busy_capt;
  logic             ins_phase;
  logic [GFC_W-1:0] cap_nib;
  ins_state_t       st;

  gfc_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .in_valid   (in_valid),
    .in_sop     (in_sop),
    .in_cell_ok (in_cell_ok),
    .cap_done   (cap_done),
    .out_ready  (out_ready),
    .start      (cap_start),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .st         (st)
  );

  gfc_sclk_gen #(.SCLK_HALF(SCLK_HALF), .NBITS(GFC_W)) u_sclk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (cap_start),
    .busy      (busy_capt),
    .sclk      (gfc_sclk),
    .msb       (gfc_msb),
    .sample_en (cap_sample),
    .done      (cap_done)
  );

  gfc_shift_rx #(.NBITS(GFC_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cap_start),
    .shift_en (cap_sample),
    .sdi      (gfc_sdi),
    .nib      (cap_nib)
  );

  assign ins_phase   = (st == ST_INS);
  assign out_data    = ins_phase ? merge_gfc(cap_nib, in_data) : in_data;
  assign out_sop     = in_sop;
  assign out_cell_ok = in_cell_ok;
endmodule

// File: rtl/gfc_serial_insert_chk.sv
module gfc_serial_insert_chk #(
  parameter int SCLK_HALF = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       in_valid,
  input logic [7:0] in_data,
  input logic       out_ready,
  input logic       in_ready,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       gfc_sclk,
  input logic       gfc_msb,
  input logic       busy_capt,
  input logic       ins_phase
);
  logic [15:0] msb_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       msb_cnt <= '0;
    else if (gfc_msb) msb_cnt <= msb_cnt + 1'b1;
    else              msb_cnt <= '0;
  end

  p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_capt |-> (!in_ready && !out_valid));

  p_msb_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gfc_msb |-> (msb_cnt < 16'(2 * SCLK_HALF)));

  p_msb_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gfc_msb) |-> ($past(msb_cnt) == 16'(2 * SCLK_HALF - 1)));

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_capt |-> (!gfc_sclk && !gfc_msb));

  p_low_nib_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[3:0] == in_data[3:0]));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_phase && in_valid && !out_ready) |=> (ins_phase && $stable(out_data[7:4])));

  p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !busy_capt && !ins_phase) |-> (out_data == in_data));
endmodule

bind gfc_serial_insert gfc_serial_insert_chk #(.SCLK_HALF(SCLK_HALF)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_ready (out_ready),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .gfc_sclk  (gfc_sclk),
  .gfc_msb   (gfc_msb),
  .busy_capt (busy_capt),
  .ins_phase (ins_phase)
);

// File: tb/sim_gfc_serial_insert.sv
module sim_gfc_serial_insert;
  localparam int HALF = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_sop = 1'b0;
  logic       in_cell_ok = 1'b0;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_sop;
  logic       out_cell_ok;
  logic       out_ready = 1'b1;
  logic       gfc_sclk;
  logic       gfc_msb;
  logic       gfc_sdi = 1'b0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  gfc_serial_insert #(.SCLK_HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop), .in_cell_ok(in_cell_ok),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_sop(out_sop), .out_cell_ok(out_cell_ok), .out_ready(out_ready),
    .gfc_sclk(gfc_sclk), .gfc_msb(gfc_msb), .gfc_sdi(gfc_sdi)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One cell: header beat, serial source model, optional back-pressure, payload.
  task automatic run_cell(input logic [7:0] hdr, input logic ok, input logic en,
                          input logic [3:0] nib, input bit bp);
    bit         ins = ok && en;
    int         msbw = 0, rises = 0, sent = 0, guard = 0;
    logic       ps = 1'b0;
    logic [7:0] exp = ins ? {nib, hdr[3:0]} : hdr;
    @(negedge clk);
    enable = en; in_valid = 1'b1; in_sop = 1'b1; in_cell_ok = ok; in_data = hdr; out_ready = 1'b1;
    #1;
    if (ins) check(!in_ready && !out_valid, "R2 stall on header", {in_ready, out_valid}, 0);
    while (!out_valid && guard < 200) begin
      @(negedge clk); #1;
      guard++;
      if (gfc_msb) msbw++;
      if (gfc_sclk && !ps) rises++;
      if (gfc_msb && sent == 0) begin gfc_sdi = nib[3]; sent = 1; end
      else if (!gfc_sclk && ps) begin
        if (sent < 4) gfc_sdi = nib[3 - sent];
        sent++;
      end
      ps = gfc_sclk;
      if (!out_valid && ins)
        check(!in_ready, "R2 stall during capture", in_ready, 0);
    end
    check(out_data == exp, ins ? "R5 inserted nibble" : (ok ? "R8 disabled pass" : "R7 idle pass"),
          out_data, exp);
    check(out_data[3:0] == hdr[3:0], "R6 low nibble kept", out_data[3:0], hdr[3:0]);
    if (ins) begin
      check(msbw == 2 * HALF, "R3 strobe width", msbw, 2 * HALF);
      check(rises == 4, "R4 sclk rising edges", rises, 4);
    end else begin
      check(!gfc_sclk && !gfc_msb && guard == 0, ok ? "R8 no serial activity" : "R7 no serial activity",
            {gfc_sclk, gfc_msb}, 0);
    end
    if (bp) begin
      out_ready = 1'b0;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk); #1;
        check(out_valid && out_data == exp && !in_ready, "R10 hold under back-pressure", out_data, exp);
      end
      @(negedge clk);
      out_ready = 1'b1;
      #1;
      check(in_ready && out_valid, "R10 release", {in_ready, out_valid}, 3);
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_sop = 1'b0; in_data = hdr ^ 8'(8'h5A + k);
      #1;
      check(out_valid && in_ready && out_data == in_data && !gfc_msb && !gfc_sclk,
            "R9 payload pass", out_data, in_data);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    check(!gfc_sclk && !gfc_msb, "R1 serial lines low", {gfc_sclk, gfc_msb}, 0);
    check(in_ready == out_ready, "R1 ready follows", in_ready, out_ready);
    out_ready = 1'b0; #1;
    check(in_ready == 1'b0, "R1 ready follows low", in_ready, 0);
    out_ready = 1'b1;
  endtask

  task automatic t_insert_patterns;
    run_cell(8'h35, 1'b1, 1'b1, 4'hA, 1'b0);
    run_cell(8'hF0, 1'b1, 1'b1, 4'h0, 1'b0);
    run_cell(8'h0C, 1'b1, 1'b1, 4'hF, 1'b0);
    run_cell(8'h81, 1'b1, 1'b1, 4'h6, 1'b0);
    run_cell(8'h27, 1'b1, 1'b1, 4'h9, 1'b0);
  endtask

  task automatic t_idle_cells;
    run_cell(8'hD3, 1'b0, 1'b1, 4'h5, 1'b0);
    run_cell(8'h00, 1'b0, 1'b1, 4'hF, 1'b0);
  endtask

  task automatic t_disabled;
    run_cell(8'h9B, 1'b1, 1'b0, 4'h3, 1'b0);
    repeat (3) @(negedge clk);
    #1;
    check(!gfc_sclk && !gfc_msb, "R8 quiet after disabled cell", {gfc_sclk, gfc_msb}, 0);
    enable = 1'b1;
  endtask

  task automatic t_backpressure;
    run_cell(8'h4E, 1'b1, 1'b1, 4'hC, 1'b1);
    run_cell(8'hB2, 1'b1, 1'b1, 4'h1, 1'b1);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_insert_patterns();
    t_idle_cells();
    t_disabled();
    t_backpressure();
    run_cell(8'h66, 1'b1, 1'b1, 4'h5, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule